// File: doc/BRIEF.md
# Group Handshake Controller

This block sequences a fixed group of child units on behalf of a parent. The parent raises its request line; the controller then activates its children, waits for each one to answer, and raises its own done line back to the parent. The parent handshake has four phases: done stays high for as long as the parent keeps its request high. The controller goes back to idle only after the parent drops the request. This lets a parent controller of the same kind see the completion at any later cycle without a race.

A build-time switch picks one of two schedules, and both use the same ports. In the concurrent schedule, every child request rises together. Each child's answer is latched, so children that finish in different cycles are all counted. The group completes once every child has answered at least once. In the ordered schedule, the children are activated one at a time, lowest index first. The controller moves to the next child only when the current child answers. All outputs are registered and decoded from the next state, and each output defaults to zero in every state.

Top module: `group_hs_ctrl`

## Requirements
- R1: A synchronous active-high reset brings the block to idle, with the parent done output low and every child request low in the cycle after the reset edge.
- R2: While idle with the parent request low, all outputs stay low whatever the child answer inputs do.
- R3: A parent request seen high while idle makes the child requests rise in the next cycle. In concurrent mode (SEQ_MODE=0) every bit rises. In ordered mode (SEQ_MODE=1) only bit 0 rises.
- R4: In concurrent mode, all child requests stay high and parent done stays low until every child has shown its answer high in at least one cycle since the group started. Single-cycle answer pulses count.
- R5: In concurrent mode, in the cycle after the last outstanding answer is seen, parent done is high and all child requests are low.
- R6: In ordered mode, at most one child request is high at any time, and child i+1 is requested in the cycle after child i answers while requested.
- R7: In ordered mode, answers from children that are not currently requested have no effect. The current request holds until its own child answers.
- R8: In ordered mode, an answer from the highest-index child makes parent done high in the next cycle, with all child requests low.
- R9: Parent done stays high while the parent request stays high. It falls in the cycle after the request is seen low, and the block is then idle.
- R10: Parent done and any child request are never high in the same cycle.
- R11: In concurrent mode, answers latched during one group are cleared on return to idle, so a new group waits for fresh answers from every child.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| p_valid | input | 1 | Request from the parent |
| c_ready | input | NUM_CHILD | Answer (done) from each child |
| p_ready | output | 1 | Done indication to the parent |
| c_valid | output | NUM_CHILD | Request to each child |

## Verification
Some properties are checked by assertions on every cycle:
- done and any child request never overlap;
- ordered mode never requests more than one child;
- concurrent requests are all-or-none;
- idle and done hold while their exit condition is absent;
- the step index and the latched-answer set never go backwards.

Other behaviour only the bench scenarios can show:
- the exact cycle of each transition under random child latency;
- pulse-style answers being counted;
- stray answers in ordered mode being ignored;
- answers being cleared between back-to-back groups.

The bench checks these against a reference model that is driven by the same stimulus.

// File: rtl/grp_hs_pkg.sv
package grp_hs_pkg;
  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_RUN  = 2'd1,
    PH_DONE = 2'd2
  } grp_phase_t;
endpackage

// File: rtl/grp_phase_fsm.sv
module grp_phase_fsm
  import grp_hs_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       p_valid,
  input  logic       run_done,
  output grp_phase_t phase_q,
  output grp_phase_t phase_d
);

  always_comb begin
    phase_d = phase_q;
    unique case (phase_q)
      PH_IDLE: if (p_valid)  phase_d = PH_RUN;
      PH_RUN:  if (run_done) phase_d = PH_DONE;
      PH_DONE: if (!p_valid) phase_d = PH_IDLE;
      default:               phase_d = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) phase_q <= PH_IDLE;
    else     phase_q <= phase_d;
  end

  AST_IDLE_WAITS: assert property (@(posedge clk) disable iff (rst)
    (phase_q == PH_IDLE && !p_valid) |=> (phase_q == PH_IDLE)); // R2

  AST_DONE_WAITS: assert property (@(posedge clk) disable iff (rst)
    (phase_q == PH_DONE && p_valid) |=> (phase_q == PH_DONE)); // R9

  AST_DONE_EXIT: assert property (@(posedge clk) disable iff (rst)
    (phase_q == PH_DONE && !p_valid) |=> (phase_q == PH_IDLE)); // R9

endmodule

// File: rtl/grp_par_tracker.sv
module grp_par_tracker #(
  parameter int NUM_CHILD = 4
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 active,
  input  logic [NUM_CHILD-1:0] c_ready,
  output logic                 all_done
);

  logic [NUM_CHILD-1:0] seen_q;

  always_ff @(posedge clk) begin
    if (rst || !active) seen_q <= '0;
    else                seen_q <= seen_q | c_ready;
  end

  assign all_done = &(seen_q | c_ready);

  AST_SEEN_CLEARED: assert property (@(posedge clk) disable iff (rst)
    !active |=> (seen_q == '0)); // R11

  AST_SEEN_STICKY: assert property (@(posedge clk) disable iff (rst)
    (active && !all_done) |=> ((seen_q & $past(seen_q)) == $past(seen_q))); // R4

endmodule

// File: rtl/grp_seq_stepper.sv
module grp_seq_stepper #(
  parameter int NUM_CHILD = 4,
  localparam int IDXW = (NUM_CHILD > 1) ? $clog2(NUM_CHILD) : 1
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 start,
  input  logic                 active,
  input  logic [NUM_CHILD-1:0] c_ready,
  output logic [IDXW-1:0]      idx_q,
  output logic [IDXW-1:0]      idx_d,
  output logic                 last_done
);

  localparam logic [IDXW-1:0] LAST = IDXW'(NUM_CHILD - 1);

  logic cur_ans;

  assign cur_ans   = active && c_ready[idx_q];
  assign last_done = cur_ans && (idx_q == LAST);

  always_comb begin
    idx_d = idx_q;
    if (start)                         idx_d = '0;
    else if (cur_ans && idx_q != LAST) idx_d = idx_q + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) idx_q <= '0;
    else     idx_q <= idx_d;
  end

  AST_STEP_HOLD: assert property (@(posedge clk) disable iff (rst)
    (active && !c_ready[idx_q]) |=> (idx_q == $past(idx_q))); // R7

  AST_STEP_RANGE: assert property (@(posedge clk) disable iff (rst)
    idx_q <= LAST); // R6

endmodule

// File: rtl/group_hs_ctrl.sv
module group_hs_ctrl
  import grp_hs_pkg::*;
#(
  parameter int NUM_CHILD = 4,
  parameter bit SEQ_MODE  = 1'b0
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 p_valid,
  input  logic [NUM_CHILD-1:0] c_ready,
  output logic                 p_ready,
  output logic [NUM_CHILD-1:0] c_valid
);

  grp_phase_t           phase_q;
  grp_phase_t           phase_d;
  logic                 active;
  logic                 start;
  logic                 run_done;
  logic [NUM_CHILD-1:0] run_mask;

  assign active = (phase_q == PH_RUN);
  assign start  = (phase_q == PH_IDLE) && p_valid;

  grp_phase_fsm u_fsm (
    .clk      (clk),
    .rst      (rst),
    .p_valid  (p_valid),
    .run_done (run_done),
    .phase_q  (phase_q),
    .phase_d  (phase_d)
  );

  generate
    if (SEQ_MODE) begin : g_seq
      localparam int IDXW = (NUM_CHILD > 1) ? $clog2(NUM_CHILD) : 1;
      logic [IDXW-1:0] idx_q;
      logic [IDXW-1:0] idx_d;
      logic            last_done;

      grp_seq_stepper #(.NUM_CHILD(NUM_CHILD)) u_step (
        .clk       (clk),
        .rst       (rst),
        .start     (start),
        .active    (active),
        .c_ready   (c_ready),
        .idx_q     (idx_q),
        .idx_d     (idx_d),
        .last_done (last_done)
      );

      assign run_done = last_done;
      assign run_mask = NUM_CHILD'(1) << idx_d;

      AST_ONE_AT_A_TIME: assert property (@(posedge clk) disable iff (rst)
        $onehot0(c_valid)); // R6

      for (genvar gi = 0; gi < NUM_CHILD - 1; gi++) begin : g_order
        AST_NEXT_CHILD: assert property (@(posedge clk) disable iff (rst)
          (c_valid[gi] && c_ready[gi]) |=> c_valid[gi+1]); // R6
      end

      AST_LAST_TO_DONE: assert property (@(posedge clk) disable iff (rst)
        (c_valid[NUM_CHILD-1] && c_ready[NUM_CHILD-1]) |=> p_ready); // R8
    end else begin : g_par
      logic all_done;

      grp_par_tracker #(.NUM_CHILD(NUM_CHILD)) u_track (
        .clk      (clk),
        .rst      (rst),
        .active   (active),
        .c_ready  (c_ready),
        .all_done (all_done)
      );

      assign run_done = all_done;
      assign run_mask = '1;

      AST_ALL_OR_NONE: assert property (@(posedge clk) disable iff (rst)
        (c_valid == '0) || (&c_valid)); // R3

      AST_ALL_ANSWERED: assert property (@(posedge clk) disable iff (rst)
        ((&c_valid) && (&c_ready)) |=> (p_ready && c_valid == '0)); // R5
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      p_ready <= 1'b0;
      c_valid <= '0;
    end else begin
      p_ready <= 1'b0;
      c_valid <= '0;
      if (phase_d == PH_DONE) p_ready <= 1'b1;
      if (phase_d == PH_RUN)  c_valid <= run_mask;
    end
  end

  AST_NO_OVERLAP: assert property (@(posedge clk) disable iff (rst)
    !(p_ready && (c_valid != '0))); // R10

  AST_START_RISE: assert property (@(posedge clk) disable iff (rst)
    (!p_ready && c_valid == '0 && p_valid) |=> (c_valid != '0)); // R3

  AST_DONE_STAYS: assert property (@(posedge clk) disable iff (rst)
    (p_ready && p_valid) |=> p_ready); // R9

endmodule

// File: tb/group_hs_ctrl_tb.sv
`timescale 1ns/1ps
module group_hs_ctrl_tb;
  localparam int N = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic pv0 = 1'b0, pv1 = 1'b0;
  logic [N-1:0] rd0 = '0, rd1 = '0;
  logic pr0, pr1;
  logic [N-1:0] cv0, cv1;

  always #2.5 clk = ~clk;

  group_hs_ctrl #(.NUM_CHILD(N), .SEQ_MODE(1'b0)) u_dut (
    .clk(clk), .rst(rst), .p_valid(pv0), .c_ready(rd0), .p_ready(pr0), .c_valid(cv0));

  group_hs_ctrl #(.NUM_CHILD(N), .SEQ_MODE(1'b1)) u_dut_seq (
    .clk(clk), .rst(rst), .p_valid(pv1), .c_ready(rd1), .p_ready(pr1), .c_valid(cv1));

  typedef struct {
    int           due;
    int           m;
    logic         epr;
    logic [N-1:0] ecv;
    string        tag;
  } item_t;

  item_t q[$];
  int ncnt = 0;
  int total = 0;
  int bad = 0;
  bit finished = 0;

  // reference model, one per instance (0 = concurrent, 1 = ordered)
  int           mst[2];
  int           midx[2];
  logic [N-1:0] mflg[2];
  logic         mpr[2];
  logic [N-1:0] mcv[2];

  function automatic void model_reset();
    for (int m = 0; m < 2; m++) begin
      mst[m] = 0; midx[m] = 0; mflg[m] = '0; mpr[m] = 1'b0; mcv[m] = '0;
    end
  endfunction

  function automatic void model_step(int m, logic v, logic [N-1:0] r);
    case (mst[m])
      0: if (v) begin mst[m] = 1; midx[m] = 0; mflg[m] = '0; end
      1: begin
        if (m == 0) begin
          if (&(mflg[m] | r)) mst[m] = 2;
          else                mflg[m] = mflg[m] | r;
        end else if (r[midx[m]]) begin
          if (midx[m] == N - 1) mst[m] = 2;
          else                  midx[m] = midx[m] + 1;
        end
      end
      default: if (!v) mst[m] = 0;
    endcase
    mpr[m] = (mst[m] == 2);
    if (mst[m] == 1) mcv[m] = (m == 0) ? {N{1'b1}} : (N'(1) << midx[m]);
    else             mcv[m] = '0;
  endfunction

  task automatic drive(int m, logic v, logic [N-1:0] r, string ovr);
    int prev;
    string tag;
    @(negedge clk); #1;
    if (m == 0) begin pv0 = v; rd0 = r; end
    else        begin pv1 = v; rd1 = r; end
    prev = mst[m];
    model_step(m, v, r);
    model_step(1 - m, (m == 0) ? pv1 : pv0, (m == 0) ? rd1 : rd0);
    if (prev == 0)          tag = (mst[m] == 1) ? "R3" : "R2";
    else if (prev == 2)     tag = "R9";
    else if (mst[m] == 2)   tag = (m == 0) ? "R5" : "R8";
    else if (ovr != "")     tag = ovr;
    else                    tag = (m == 0) ? "R4" : "R7";
    q.push_back('{due: ncnt + 1, m: m, epr: mpr[m], ecv: mcv[m], tag: tag});
  endtask

  task automatic run_txn(int m, bit pulse, bit noise, string ovr);
    int dly[N];
    bit ans[N];
    logic [N-1:0] r;
    int guard = 0;
    for (int i = 0; i < N; i++) begin dly[i] = 1 + int'($urandom % 5); ans[i] = 0; end
    drive(m, 1'b1, '0, ovr);
    while (mst[m] == 1 && guard < 200) begin
      for (int i = 0; i < N; i++) begin
        r[i] = 1'b0;
        if (mcv[m][i]) begin
          if (!ans[i]) begin
            if (dly[i] == 0) begin r[i] = 1'b1; if (pulse) ans[i] = 1; end
            else dly[i]--;
          end
        end else if (noise) r[i] = 1'($urandom % 2);
      end
      drive(m, 1'b1, r, ovr);
      guard++;
    end
    for (int k = 0; k < 3; k++) drive(m, 1'b1, N'($urandom), "");
    drive(m, 1'b0, '0, "");
    drive(m, 1'b0, '0, "");
  endtask

  // monitor: pops scoreboard items as their cycle comes due
  always @(negedge clk) begin
    ncnt++;
    while (q.size() > 0 && q[0].due <= ncnt) begin
      item_t it;
      logic apr;
      logic [N-1:0] acv;
      it  = q.pop_front();
      apr = (it.m == 0) ? pr0 : pr1;
      acv = (it.m == 0) ? cv0 : cv1;
      total++;
      if (apr !== it.epr || acv !== it.ecv) begin
        bad++;
        $display("FAIL %s dut%0d: p_ready=%b c_valid=%b expected p_ready=%b c_valid=%b",
                 it.tag, it.m, apr, acv, it.epr, it.ecv);
      end
    end
    if (!rst) begin
      total++;
      if ((pr0 && cv0 != '0) || (pr1 && cv1 != '0)) begin
        bad++;
        $display("FAIL R10: done=%b/%b with requests %b/%b, expected no overlap", pr0, pr1, cv0, cv1);
      end
      total++;
      if ($countones(cv1) > 1) begin
        bad++;
        $display("FAIL R6: ordered requests %b, expected at most one bit", cv1);
      end
    end
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!finished) begin
      bad++;
      total++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd7));
    model_reset();
    repeat (2) @(negedge clk);
    #1;
    // R1: outputs low after a reset edge
    q.push_back('{due: ncnt + 1, m: 0, epr: 1'b0, ecv: '0, tag: "R1"});
    q.push_back('{due: ncnt + 1, m: 1, epr: 1'b0, ecv: '0, tag: "R1"});
    @(negedge clk); #1;
    rst = 1'b0;

    // R2: idle ignores stray answers
    for (int m = 0; m < 2; m++)
      for (int k = 0; k < 4; k++) drive(m, 1'b0, N'($urandom), "");

    // concurrent: pulse answers (R4), held answers, back-to-back clearing (R11)
    run_txn(0, 1'b1, 1'b0, "");
    run_txn(0, 1'b0, 1'b0, "");
    run_txn(0, 1'b1, 1'b0, "");
    run_txn(0, 1'b1, 1'b0, "R11");

    // ordered: clean answers, then stray answers from other children (R7)
    run_txn(1, 1'b1, 1'b0, "R6");
    run_txn(1, 1'b0, 1'b1, "R7");
    run_txn(1, 1'b1, 1'b1, "R7");

    for (int k = 0; k < 6; k++) begin
      run_txn(0, 1'($urandom % 2), 1'b0, "");
      run_txn(1, 1'($urandom % 2), 1'b1, "");
    end

    repeat (3) @(negedge clk);
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule